// File: doc/BRIEF.md
# UART Start-Edge Wake-Up Controller

This block sits in front of a UART receiver whose bit clock is normally gated off to save power. It watches the asynchronous receive line. When it sees a falling edge that marks a start bit, it sets a latched start flag, raises the receive interrupt and turns on the receiver's bit clock. The clock then runs until the receiver reports that the stop bit of the current character has been sampled. After that it is gated off again until the next start edge arrives.

Start-edge events and completed characters drive one shared interrupt. Software tells them apart with the receive-complete flag: if that flag is clear, the interrupt came from a frame start. Software re-arms the start latch by driving the enable bit low and then high. Driving it low clears the latch and blocks further start-edge requests.

A line-break detector counts baud ticks while the line is held low. It counts only while the bit clock is enabled. A break that happens while the clock is gated therefore goes unreported.

Top module: `uart_wake_ctrl`

## Requirements
- R1: After reset, bitclk_en_o, irq_o, start_flag_o, rx_done_o and break_o are all 0.
- R2: With arm_en_i high and start_flag_o clear, a high-to-low change of rx_i sets start_flag_o. The flag appears after the third rising clock edge following the change (two synchronizer flops plus one edge register), and not after the second.
- R3: bitclk_en_o rises on the same edge that sets start_flag_o.
- R4: irq_o is high exactly when start_flag_o or rx_done_o is high. An interrupt with rx_done_o at 0 identifies a frame start.
- R5: While arm_en_i is low, start_flag_o is cleared on the next edge. Falling edges on rx_i during that time neither set the flag nor enable the bit clock.
- R6: Once start_flag_o is set, further falling edges have no effect on the flag. After arm_en_i returns high from low, the next falling edge sets the flag again.
- R7: A char_done_i pulse clears bitclk_en_o on the next edge, unless a start edge is accepted in that same cycle, in which case the clock stays enabled.
- R8: char_done_i sets rx_done_o on the next edge. data_read_i clears it. When both are asserted in the same cycle, the set wins.
- R9: break_o sets once BRK_BITS baud_tick_i pulses have arrived while the synchronized line is low and bitclk_en_o is high. Ticks while the clock is gated are not counted. A high line restarts the count. data_read_i clears break_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous receive line, idles high |
| arm_en_i | input | 1 | Start-edge enable bit; low clears and blocks the latch |
| char_done_i | input | 1 | Pulse from the receiver: stop bit sampled |
| data_read_i | input | 1 | Pulse: software read the received data |
| baud_tick_i | input | 1 | Bit-period tick from the baud divider |
| bitclk_en_o | output | 1 | Enable for the receiver bit clock |
| irq_o | output | 1 | Shared receive interrupt request |
| start_flag_o | output | 1 | Latched start-edge flag |
| rx_done_o | output | 1 | Receive-complete flag |
| break_o | output | 1 | Line-break flag |

## Verification
The hardest case to reach is a break that arrives while the bit clock is gated. The line must already be low when the receiver reports the stop bit. The clock then shuts off with the line still held low, and only after that do the baud ticks arrive. The stimulus builds this by starting a frame, holding the line low, pulsing char_done_i, and then sending more ticks than BRK_BITS. The break flag must stay clear through all of them. The bench also crosses a disarm with line edges, and sends a second start edge while the latch is already set.

// File: rtl/uwk_pkg.sv
package uwk_pkg;

   // per-cycle event bundle passed from the edge front end to the status logic
   typedef struct packed {
      logic fall;       // synchronized falling edge on the line
      logic start_set;  // start edge accepted this cycle
      logic char_done;  // receiver sampled a stop bit
      logic data_read;  // software consumed the data
   } uwk_evt_t;

   function automatic int unsigned uwk_cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/uwk_rx_sync.sv
module uwk_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic rx_s_o,
   output logic fall_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uwk_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   // first stage samples the raw line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= rx_i;
   end

   // remaining stages form a chain
   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rx_s_o = sync_q[STAGES-1];
   assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/uwk_start_latch.sv
module uwk_start_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic fall_i,
   output logic flag_o,
   output logic set_o
);

   logic flag_q;

   // an edge is accepted only when armed and not already latched
   assign set_o = fall_i & arm_i & ~flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (!arm_i) flag_q <= 1'b0;
      else if (set_o)  flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/uwk_clk_gate.sv
module uwk_clk_gate #(
   parameter bit AUTO_STOP = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_set_i,
   input  logic char_done_i,
   input  logic arm_i,
   output logic en_o
);

   logic en_q;
   logic stop_req;

   generate
      if (AUTO_STOP) begin : g_auto
         // stop after every completed character
         assign stop_req = char_done_i;
      end else begin : g_hold
         // keep running until software disarms and the character ends
         assign stop_req = char_done_i & ~arm_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           en_q <= 1'b0;
      else if (start_set_i) en_q <= 1'b1;
      else if (stop_req)    en_q <= 1'b0;
   end

   assign en_o = en_q;

endmodule

// File: rtl/uwk_rx_status.sv
module uwk_rx_status
   import uwk_pkg::*;
#(
   parameter int unsigned BRK_BITS = 10
) (
   input  logic     clk,
   input  logic     rst_n,
   input  uwk_evt_t evt_i,
   input  logic     rx_s_i,
   input  logic     tick_i,
   input  logic     clk_en_i,
   output logic     done_o,
   output logic     brk_o
);

   localparam int unsigned CW = uwk_cnt_width(BRK_BITS);
   localparam logic [CW-1:0] LIM    = CW'(BRK_BITS);
   localparam logic [CW-1:0] LIM_M1 = CW'(BRK_BITS - 1);

   generate
      if (BRK_BITS < 1) begin : g_bad_brk
         $error("uwk_rx_status: BRK_BITS must be at least 1");
      end
   endgenerate

   logic          done_q;
   logic          brk_q;
   logic [CW-1:0] low_cnt_q;
   logic          cnt_inc;
   logic          brk_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               done_q <= 1'b0;
      else if (evt_i.char_done) done_q <= 1'b1;
      else if (evt_i.data_read) done_q <= 1'b0;
   end

   // low-line bit counter only advances on ticks of a running bit clock
   assign cnt_inc = ~rx_s_i & tick_i & clk_en_i & (low_cnt_q != LIM);
   assign brk_set = cnt_inc & (low_cnt_q == LIM_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_cnt_q <= '0;
      else if (rx_s_i)  low_cnt_q <= '0;
      else if (cnt_inc) low_cnt_q <= low_cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               brk_q <= 1'b0;
      else if (brk_set)         brk_q <= 1'b1;
      else if (evt_i.data_read) brk_q <= 1'b0;
   end

   assign done_o = done_q;
   assign brk_o  = brk_q;

endmodule

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
   import uwk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BRK_BITS    = 10,
   parameter bit          AUTO_STOP   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   input  logic arm_en_i,
   input  logic char_done_i,
   input  logic data_read_i,
   input  logic baud_tick_i,
   output logic bitclk_en_o,
   output logic irq_o,
   output logic start_flag_o,
   output logic rx_done_o,
   output logic break_o
);

   logic     rx_s;
   logic     fall;
   logic     start_set;
   logic     flag;
   logic     clk_en;
   logic     done;
   logic     brk;
   uwk_evt_t evt;

   uwk_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .rx_s_o (rx_s),
      .fall_o (fall)
   );

   uwk_start_latch latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (arm_en_i),
      .fall_i (fall),
      .flag_o (flag),
      .set_o  (start_set)
   );

   uwk_clk_gate #(.AUTO_STOP(AUTO_STOP)) gate_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_set_i (start_set),
      .char_done_i (char_done_i),
      .arm_i       (arm_en_i),
      .en_o        (clk_en)
   );

   assign evt = '{fall: fall, start_set: start_set,
                  char_done: char_done_i, data_read: data_read_i};

   uwk_rx_status #(.BRK_BITS(BRK_BITS)) status_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt),
      .rx_s_i   (rx_s),
      .tick_i   (baud_tick_i),
      .clk_en_i (clk_en),
      .done_o   (done),
      .brk_o    (brk)
   );

   // one request line shared by frame start and completed character
   assign irq_o        = flag | done;
   assign bitclk_en_o  = clk_en;
   assign start_flag_o = flag;
   assign rx_done_o    = done;
   assign break_o      = brk;

endmodule

// File: rtl/uwk_checker.sv
module uwk_checker #(
   parameter bit AUTO_STOP = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic arm_en_i,
   input logic char_done_i,
   input logic data_read_i,
   input logic bitclk_en_o,
   input logic irq_o,
   input logic start_flag_o,
   input logic rx_done_o,
   input logic break_o
);

   // R1: outputs idle on the first cycle out of reset
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!bitclk_en_o && !irq_o && !start_flag_o && !rx_done_o && !break_o));

   // R3: a newly latched start always comes with the clock enabled
   a_r3_flag_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag_o) |-> bitclk_en_o);

   // R4: an interrupt without a completed character means a latched start
   a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !rx_done_o) |-> start_flag_o);

   // R5: disarming clears the latch on the next edge
   a_r5_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_en_i |=> !start_flag_o);

   // R8: completed character raises the flag
   a_r8_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      char_done_i |=> rx_done_o);

   // R8: a read with no concurrent completion clears the flag
   a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (data_read_i && !char_done_i) |=> !rx_done_o);

   // R9: a break can only appear while the bit clock was running
   a_r9_break_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(break_o) |-> $past(bitclk_en_o));

   generate
      if (AUTO_STOP) begin : g_auto_chk
         // R7: stop bit gates the clock unless a start could be taken
         a_r7_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
            (char_done_i && !(arm_en_i && !start_flag_o)) |=> !bitclk_en_o);
      end
   endgenerate

endmodule

bind uart_wake_ctrl uwk_checker #(.AUTO_STOP(AUTO_STOP)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm_en_i     (arm_en_i),
   .char_done_i  (char_done_i),
   .data_read_i  (data_read_i),
   .bitclk_en_o  (bitclk_en_o),
   .irq_o        (irq_o),
   .start_flag_o (start_flag_o),
   .rx_done_o    (rx_done_o),
   .break_o      (break_o)
);

// File: tb/uart_wake_ctrl_tb_top.sv
module uart_wake_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int BRK        = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1, arm = 1'b0, cdone = 1'b0, dread = 1'b0, tick = 1'b0;
   logic clk_en, irq, sflag, rdone, brk;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_wake_ctrl #(.SYNC_STAGES(SYNC), .BRK_BITS(BRK), .AUTO_STOP(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .arm_en_i(arm),
      .char_done_i(cdone), .data_read_i(dread), .baud_tick_i(tick),
      .bitclk_en_o(clk_en), .irq_o(irq), .start_flag_o(sflag),
      .rx_done_o(rdone), .break_o(brk)
   );

   // behavioural reference: line history queue plus plain state bits
   bit m_hist[$];
   bit m_prev, m_flag, m_en, m_done, m_brk;
   int m_low;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hist = {};
         for (int i = 0; i < SYNC; i++) m_hist.push_back(1'b1);
         m_prev = 1'b1; m_flag = 0; m_en = 0; m_done = 0; m_brk = 0; m_low = 0;
      end else begin
         bit line, take, brk_now;
         line = m_hist[SYNC-1];
         take = m_prev && !line && arm && !m_flag;
         brk_now = 0;
         if (line) m_low = 0;
         else if (tick && m_en && m_low < BRK) begin
            m_low++;
            if (m_low == BRK) brk_now = 1;
         end
         if (brk_now) m_brk = 1; else if (dread) m_brk = 0;
         if (cdone) m_done = 1; else if (dread) m_done = 0;
         if (take) m_en = 1; else if (cdone) m_en = 0;
         if (!arm) m_flag = 0; else if (take) m_flag = 1;
         m_prev = line;
         void'(m_hist.pop_back());
         m_hist.push_front(rx);
      end
   end

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      chk("R3 bitclk_en", clk_en, m_en);
      chk("R4 irq", irq, m_flag | m_done);
      chk("R2 start_flag", sflag, m_flag);
      chk("R8 rx_done", rdone, m_done);
      chk("R9 break", brk, m_brk);
   endtask

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (rst_n) cmp_all();
      end
   endtask

   task automatic pulse_char_done();
      cdone = 1; step(); cdone = 0;
   endtask

   task automatic pulse_read();
      dread = 1; step(); dread = 0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1; step(); tick = 0; step();
      end
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 bitclk_en", clk_en, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 flags", sflag | rdone | brk, 1'b0);

      // R2/R3: start edge latency
      arm = 1; step(2);
      rx = 0;
      step(2);
      chk("R2 not yet after two edges", sflag, 1'b0);
      step();
      chk("R2 start latched", sflag, 1'b1);
      chk("R3 clock enabled with start", clk_en, 1'b1);
      chk("R4 irq from start, done clear", irq & !rdone, 1'b1);

      // R6: second edge while latched has no effect
      rx = 1; step(4); rx = 0; step(5);
      chk("R6 latched flag unchanged", sflag, 1'b1);

      // R7/R8: character completes
      rx = 1; step(4);
      pulse_char_done();
      chk("R7 clock gated after stop", clk_en, 1'b0);
      chk("R8 done set", rdone, 1'b1);
      pulse_read();
      chk("R8 done cleared by read", rdone, 1'b0);
      chk("R4 irq still from start", irq, 1'b1);

      // R8: set wins over read
      cdone = 1; dread = 1; step(); cdone = 0; dread = 0;
      chk("R8 set wins over read", rdone, 1'b1);
      pulse_read();

      // R5: disarm clears and blocks edges
      arm = 0; step();
      chk("R5 disarm clears flag", sflag, 1'b0);
      chk("R4 irq drops", irq, 1'b0);
      rx = 0; step(5); rx = 1; step(3); rx = 0; step(5);
      chk("R5 edge ignored: flag", sflag, 1'b0);
      chk("R5 edge ignored: clock", clk_en, 1'b0);

      // R6: re-arm then a fresh edge latches again
      rx = 1; step(4); arm = 1; step();
      rx = 0; step(3);
      chk("R6 re-armed start", sflag, 1'b1);
      chk("R3 clock on again", clk_en, 1'b1);

      // R9: break with running clock (line held low)
      ticks(BRK - 1);
      chk("R9 no break one tick short", brk, 1'b0);
      ticks(1);
      chk("R9 break after BRK_BITS ticks", brk, 1'b1);
      pulse_read();
      chk("R9 break cleared by read", brk, 1'b0);

      // R9: high line restarts the count
      rx = 1; step(4); rx = 0; step(3);
      ticks(BRK - 1);
      chk("R9 count restarted by high line", brk, 1'b0);

      // R7/R9: clock gated while line stays low, ticks ignored
      pulse_char_done();
      chk("R7 clock gated with line low", clk_en, 1'b0);
      ticks(BRK + 2);
      chk("R9 no break while gated", brk, 1'b0);
      pulse_read();

      // R7: start accepted in the same cycle as a stop keeps the clock
      arm = 0; step(); arm = 1; rx = 1; step(4);
      rx = 0; step(2);
      cdone = 1; step(); cdone = 0;
      chk("R7 start wins over stop", clk_en, 1'b1);
      step(3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule